// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a write-and-read slave on a two-wire serial control bus. It oversamples the bus clock and data lines with the local system clock and drives the data line only by pulling it low, through an open-drain request output. It holds a small bank of control bytes and presents them all at once on a parallel output that the rest of the chip uses as configuration.

Three strap inputs pick the bus address from a fixed table of eight, so several copies can share one bus. A write carries the address, then a command byte and a count byte, both acknowledged and then discarded, then data. There is no register offset, so data always lands from byte 0 upward. A read returns the number of control bytes, then the bytes themselves in order. The serial bus is the only data path and it cannot be stalled: the slave never stretches the clock, so there is no back-pressure, and the strap pins and register outputs are plain levels.

Top module: `ctl_twowire_slave`

## Requirements
- R1: A start (data falling while clock is high) aborts any transfer in progress and begins address reception. A stop (data rising while clock is high) ends the transfer. A data byte cut short by either condition is not stored.
- R2: Address byte from the straps {strap_i[2], strap_i[1], strap_i[0]}: 000 gives 0xDE, 001 gives 0xDC, 010 gives 0xDA, 011 gives 0xD8, 100 gives 0xD6, 101 gives 0xD4, 110 gives 0xD0, 111 gives 0xD2. Bits 7:1 are the 7-bit address and bit 0 is the direction bit, where 1 means read.
- R3: An address that does not match gets no acknowledge. The slave then releases the line and stores nothing until the next start.
- R4: In a matching write, the slave acknowledges the address byte, the command byte, the count byte and each accepted data byte by pulling data low for the ninth clock pulse.
- R5: The values of the command and count bytes have no effect on where data is stored or on how much is stored.
- R6: Data bytes are stored at indices 0, 1, 2 and upward in arrival order. Every write starts again at index 0. Bytes that are not written keep their value.
- R7: Only NREG data bytes (10 by default) are accepted. Any data byte after that gets no acknowledge and is not stored.
- R8: After reset, byte 0 is 0xA1 and every other byte is 0xFF. The data line is released.
- R9: In a read, the slave sends the value NREG first, then bytes 0 to NREG-1, most significant bit first. It sends one more byte each time the master acknowledges. Bytes past the last register read as 0xFF. A master not-acknowledge ends the read.
- R10: The pull-low request changes only while the bus clock is low. Each clock phase needs to last only a few system clocks, so standard-mode 100 kbit/s works with any system clock of a few MHz or faster.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| strap_i | input | 3 | Address strap pins, bit 2 most significant |
| sda_pull_o | output | 1 | 1 = pull the data line low, 0 = release it |
| regs_o | output | NREG*8 | Control bytes, byte i at bits 8i+7:8i |

## Verification
Two events can land on the same system-clock cycle. The first pair is the storing of the last accepted data byte and the decision to refuse the next one. This is provoked with a write of eleven data bytes, and it is judged by the tenth acknowledge, the eleventh refusal and the final register contents. The second pair is a start or stop arriving in the middle of a data byte, while the receive shifter is still filling. The bench cuts a byte after a few bits with a repeated start, and another with a stop. It then checks that nothing is stored and that the next write still fills from byte 0.

// File: rtl/twsl_pkg.sv
package twsl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK, ST_WAIT
  } twsl_state_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_CMD, PH_CNT, PH_DATA
  } twsl_phase_e;

  // address byte picked by the three strap pins (R2)
  function automatic logic [7:0] strap_addr(input logic [2:0] s);
    if (s < 3'd6) return 8'hDE - {4'd0, s, 1'b0};
    return s[0] ? 8'hD2 : 8'hD0;
  endfunction

  // power-on value of each control byte (R8)
  function automatic logic [7:0] reset_byte(input int idx);
    return (idx == 0) ? 8'hA1 : 8'hFF;
  endfunction

endpackage

// File: rtl/twsl_line_sync.sv
module twsl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] pipe_q;
  logic         last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
      last_q <= 1'b1;
    end else begin
      pipe_q <= {pipe_q[TOP-1:0], line_i};
      last_q <= pipe_q[TOP];
    end
  end

  assign level_o = pipe_q[TOP];
  assign rise_o  = pipe_q[TOP] & ~last_q;
  assign fall_o  = ~pipe_q[TOP] & last_q;
endmodule

// File: rtl/twsl_addr_table.sv
module twsl_addr_table
  import twsl_pkg::*;
(
  input  logic [2:0] strap_i,
  output logic [6:0] addr7_o
);
  logic [7:0] addr8;
  assign addr8   = strap_addr(strap_i);
  assign addr7_o = addr8[7:1];
endmodule

// File: rtl/twsl_regbank.sv
module twsl_regbank
  import twsl_pkg::*;
#(
  parameter int NREG = 10,
  parameter int PW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PW-1:0]     wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [PW-1:0]     rd_idx,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] regs_o
);
  localparam logic [PW-1:0] LIMIT = PW'(NREG);

  logic [NREG*8-1:0] regs_q;

  for (genvar g = 0; g < NREG; g++) begin : g_byte
    localparam logic [7:0] INIT = reset_byte(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              regs_q[g*8 +: 8] <= INIT;
      else if (wr_en && wr_idx == PW'(g))      regs_q[g*8 +: 8] <= wr_data;
    end
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == PW'(i)) rd_data = regs_q[i*8 +: 8];
  end

  assign regs_o = regs_q;

  // R7: the controller never asks for a store past the last byte
  assert_wr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < LIMIT));

  // R3: without a store request the bank holds its contents
  assert_hold_without_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));
endmodule

// File: rtl/ctl_twowire_slave.sv
module ctl_twowire_slave
  import twsl_pkg::*;
#(
  parameter int NREG        = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  output logic              sda_pull_o,
  output logic [NREG*8-1:0] regs_o
);
  localparam int            PW       = $clog2(NREG + 2);
  localparam logic [PW-1:0] LIMIT    = PW'(NREG);
  localparam logic [PW-1:0] PAST_END = PW'(NREG + 1);
  localparam logic [7:0]    COUNT_B  = 8'(NREG);

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;

  twsl_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  twsl_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  logic [6:0] own_addr7;
  twsl_addr_table u_addr (.strap_i(strap_i), .addr7_o(own_addr7));

  twsl_state_e   state_q;
  twsl_phase_e   phase_q;
  logic [3:0]    bitcnt_q;
  logic [7:0]    shreg_q;
  logic [PW-1:0] wptr_q, rptr_q;
  logic          rd_mode_q;
  logic [7:0]    txsh_q;
  logic [2:0]    txcnt_q;
  logic          mack_q;
  logic          pull_q;

  logic start_det, stop_det;
  assign start_det = scl_lvl & sda_fall;
  assign stop_det  = scl_lvl & sda_rise;

  logic byte_end, addr_hit, byte_ack, wr_en, load_tx;
  logic [7:0]    rd_data, tx_byte;
  logic [PW-1:0] rd_idx;

  assign byte_end = (state_q == ST_RX) && scl_fall && (bitcnt_q == 4'd8);
  assign addr_hit = (shreg_q[7:1] == own_addr7);

  always_comb begin
    unique case (phase_q)
      PH_ADDR: byte_ack = addr_hit;
      PH_DATA: byte_ack = (wptr_q < LIMIT);
      default: byte_ack = 1'b1;
    endcase
  end

  assign wr_en   = byte_end && (phase_q == PH_DATA) && (wptr_q < LIMIT);
  assign rd_idx  = rptr_q - PW'(1);
  assign tx_byte = (rptr_q == '0) ? COUNT_B : rd_data;
  assign load_tx = scl_fall &&
                   (((state_q == ST_ACK) && rd_mode_q) ||
                    ((state_q == ST_TXACK) && mack_q));

  twsl_regbank #(.NREG(NREG), .PW(PW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wptr_q), .wr_data(shreg_q),
    .rd_idx(rd_idx), .rd_data(rd_data), .regs_o(regs_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_ADDR;
      bitcnt_q  <= '0;
      shreg_q   <= '0;
      wptr_q    <= '0;
      rptr_q    <= '0;
      rd_mode_q <= 1'b0;
      txsh_q    <= '0;
      txcnt_q   <= '0;
      mack_q    <= 1'b0;
      pull_q    <= 1'b0;
    end else if (start_det) begin
      state_q  <= ST_RX;
      phase_q  <= PH_ADDR;
      bitcnt_q <= '0;
      pull_q   <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      pull_q  <= 1'b0;
    end else if (load_tx) begin
      txsh_q  <= tx_byte;
      txcnt_q <= '0;
      pull_q  <= ~tx_byte[7];
      state_q <= ST_TX;
      if (rptr_q != PAST_END) rptr_q <= rptr_q + PW'(1);
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            shreg_q  <= {shreg_q[6:0], sda_lvl};
            bitcnt_q <= bitcnt_q + 4'd1;
          end
          if (byte_end) begin
            bitcnt_q <= '0;
            state_q  <= byte_ack ? ST_ACK : ST_WAIT;
            pull_q   <= byte_ack;
            unique case (phase_q)
              PH_ADDR: begin
                rd_mode_q <= shreg_q[0];
                rptr_q    <= '0;
                phase_q   <= PH_CMD;
              end
              PH_CMD:  phase_q <= PH_CNT;
              PH_CNT: begin
                phase_q <= PH_DATA;
                wptr_q  <= '0;
              end
              default: if (wr_en) wptr_q <= wptr_q + PW'(1);
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            pull_q  <= 1'b0;
            state_q <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (txcnt_q == 3'd7) begin
              pull_q  <= 1'b0;
              state_q <= ST_TXACK;
            end else begin
              txsh_q  <= {txsh_q[6:0], 1'b0};
              pull_q  <= ~txsh_q[6];
              txcnt_q <= txcnt_q + 3'd1;
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) mack_q <= ~sda_lvl;
          if (scl_fall) state_q <= ST_WAIT;
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o = pull_q;

  // R10: the pull request moves only while the synchronized clock is low
  assert_pull_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_q != $past(pull_q)) |-> !scl_lvl);

  // R3: outside a transfer the line is always released
  assert_released_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) || (state_q == ST_WAIT)) |-> !pull_q);

  // R4: an acknowledge follows a complete eight-bit byte
  assert_ack_after_full_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pull_q) && (state_q == ST_ACK)) |-> ($past(bitcnt_q) == 4'd8));
endmodule

// File: tb/ctl_twowire_slave_tb_top.sv
module ctl_twowire_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 10;
  localparam int Q          = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [2:0] strap = 3'b000;
  logic sda_pull;
  logic [NREG*8-1:0] regs;
  logic sda_bus;

  assign sda_bus = m_sda & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_twowire_slave #(.NREG(NREG)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .strap_i(strap), .sda_pull_o(sda_pull), .regs_o(regs));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int r10_viol = 0;
  logic [7:0] model [NREG];
  logic [7:0] wbuf [16];
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];

  task automatic chk(input bit ok, input string msg, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", msg, act, expv);
    end
  endtask

  function automatic logic [7:0] exp_addr(input logic [2:0] s);
    case (s)
      3'd0: return 8'hDE;  3'd1: return 8'hDC;
      3'd2: return 8'hDA;  3'd3: return 8'hD8;
      3'd4: return 8'hD6;  3'd5: return 8'hD4;
      3'd6: return 8'hD0;  default: return 8'hD2;
    endcase
  endfunction

  task automatic waitq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; waitq(Q); m_scl = 1'b1; waitq(Q);
    m_sda = 1'b0; waitq(Q); m_scl = 1'b0; waitq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; waitq(Q); m_scl = 1'b1; waitq(Q);
    m_sda = 1'b1; waitq(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; waitq(Q); m_scl = 1'b1; waitq(2*Q); m_scl = 1'b0; waitq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_sda = 1'b1; waitq(Q); m_scl = 1'b1; waitq(Q);
    ack = ~sda_bus;
    waitq(Q); m_scl = 1'b0; waitq(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitq(Q); m_scl = 1'b1; waitq(Q); b[i] = sda_bus; waitq(Q); m_scl = 1'b0; waitq(Q);
    end
    m_sda = ~give_ack; waitq(Q); m_scl = 1'b1; waitq(2*Q); m_scl = 1'b0; waitq(Q);
    m_sda = 1'b1;
  endtask

  task automatic chk_regs(input string req);
    for (int i = 0; i < NREG; i++)
      chk(regs[i*8 +: 8] == model[i], $sformatf("%s reg%0d", req, i), regs[i*8 +: 8], model[i]);
  endtask

  // write driver: header bytes then n data bytes; updates the bench model
  task automatic do_write(input logic [7:0] cmd, input logic [7:0] cnt, input int n, input string req);
    bit ak;
    bus_start();
    send_byte(exp_addr(strap), ak); chk(ak, {req, " R4 addr ack"}, ak, 1);
    send_byte(cmd, ak);             chk(ak, {req, " R4 cmd ack"}, ak, 1);
    send_byte(cnt, ak);             chk(ak, {req, " R4 count ack"}, ak, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ak);
      chk(ak == (i < NREG), $sformatf("%s data%0d ack R7", req, i), ak, i < NREG);
      if (i < NREG) model[i] = wbuf[i];
      if (!ak) break;
    end
    bus_stop();
  endtask

  // read driver: pushes expected bytes, collected bytes go to the monitor
  task automatic do_read(input int n);
    bit ak;
    logic [7:0] b;
    bus_start();
    send_byte(exp_addr(strap) | 8'h01, ak); chk(ak, "R9 read addr ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(i == 0 ? 8'(NREG) : (i <= NREG ? model[i-1] : 8'hFF));
      recv_byte(b, i != n - 1);
      got_q.push_back(b);
    end
    bus_stop();
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] g, e;
        g = got_q.pop_front(); e = exp_q.pop_front();
        chk(g == e, "R9 read byte", g, e);
      end
    end
  end

  // R10 watch: pull request changes only with the bus clock low
  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && sda_pull != prev && m_scl) r10_viol++;
      prev = sda_pull;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ak;
    for (int i = 0; i < NREG; i++) model[i] = (i == 0) ? 8'hA1 : 8'hFF;
    waitq(5); rst_n = 1'b1; waitq(5);

    // R8 reset state
    chk_regs("R8");
    chk(sda_pull == 1'b0, "R8 line released", sda_pull, 0);

    // R4 R5 R6 basic write with odd header values
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(8'h55, 8'h07, 3, "R5");
    chk_regs("R6 first write");

    // R6 second write restarts at byte 0
    wbuf[0] = 8'h44;
    do_write(8'hF0, 8'h00, 1, "R6");
    chk_regs("R6 restart at 0");

    // R3 wrong address: no ack, nothing stored
    bus_start();
    send_byte(8'hDC, ak); chk(!ak, "R3 foreign address nack", ak, 0);
    m_sda = 1'b1;
    send_byte(8'h99, ak); chk(!ak, "R3 data after nack", ak, 0);
    bus_stop();
    chk_regs("R3 no store");

    // R2 strap table
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      waitq(2);
      bus_start();
      send_byte(exp_addr(3'(s)), ak);
      chk(ak, $sformatf("R2 strap %0d own addr", s), ak, 1);
      bus_stop();
      bus_start();
      send_byte(exp_addr(3'(s + 1)), ak);
      chk(!ak, $sformatf("R2 strap %0d other addr", s), ak, 0);
      bus_stop();
    end
    strap = 3'b011;

    // R7 eleven data bytes: tenth stored, eleventh refused
    for (int i = 0; i < 11; i++) wbuf[i] = 8'(8'h60 + i * 3);
    do_write(8'h01, 8'h0B, 11, "R7");
    chk_regs("R7 overflow");

    // R9 read all plus one past the end
    do_read(NREG + 2);
    waitq(4);
    chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);

    // R1 repeated start in the middle of a data byte
    bus_start();
    send_byte(exp_addr(strap), ak);
    send_byte(8'h00, ak); send_byte(8'h00, ak);
    send_bits(8'h5A, 4);
    wbuf[0] = 8'h77;
    do_write(8'h12, 8'h34, 1, "R1 restart");
    chk_regs("R1 repeated start");

    // R1 stop in the middle of a data byte
    bus_start();
    send_byte(exp_addr(strap), ak);
    send_byte(8'h00, ak); send_byte(8'h00, ak);
    send_bits(8'hC3, 3);
    bus_stop();
    chk_regs("R1 stop abort");
    chk(sda_pull == 1'b0, "R1 released after stop", sda_pull, 0);

    wbuf[0] = 8'h0F; wbuf[1] = 8'hE1;
    do_write(8'hAA, 8'h02, 2, "R1 after abort");
    chk_regs("R1 fresh write");
    do_read(3);
    waitq(4);

    chk(r10_viol == 0, "R10 pull changes with clock low", r10_viol, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule